// File: doc/BRIEF.md
# Two-Dimensional Block Copy Engine

This engine moves one rectangular block of memory at a time. A request names a source start address, a destination start address, a line length in bytes, a number of lines, and a signed line stride for each side. Each side also picks its own addressing mode. In incrementing mode the address steps by one beat width within a line. In constant mode every beat of a line uses the line start address, which suits a FIFO-style peripheral. Data moves in 64-bit beats. Each beat is read over a valid/ready read port, and the same beat is then written over a valid/ready write port. Each access carries the priority level of its request.

Accepted requests wait in a four-entry in-order table. The request at the head of the table is the one being executed. It leaves the table only when its completion pulse is sent, so "outstanding" includes the running request. A completion returns the request's own tag and a pass/fail flag. A malformed line length causes an immediate failed completion. So does an error response from either memory port, which also abandons the rest of the request.

The sequencer uses these states: `S_IDLE`, `S_LOAD`, `S_RD_ADDR`, `S_RD_WAIT`, `S_WR_ADDR`, `S_WR_WAIT` and `S_RETIRE`.
- `S_IDLE` to `S_LOAD` when the table holds a request.
- `S_LOAD` to `S_RETIRE` on a bad length or a zero line count; otherwise `S_LOAD` to `S_RD_ADDR`.
- `S_RD_ADDR` to `S_RD_WAIT` on a read handshake.
- `S_RD_WAIT` to `S_WR_ADDR` on a clean read response, or to `S_RETIRE` on an errored one.
- `S_WR_ADDR` to `S_WR_WAIT` on a write handshake.
- `S_WR_WAIT` to `S_RD_ADDR` after a clean write response when beats remain. It goes to `S_RETIRE` after the last beat or on an errored write response.
- `S_RETIRE` to `S_IDLE` always.

Top module: `blk2d_mover`

## Requirements
- R1: After reset `req_ready` is 1 and `rd_valid`, `wr_valid` and `done_valid` are 0.
- R2: No more than 4 requests are outstanding between acceptance and completion. `req_ready` is 0 while 4 are outstanding.
- R3: In incrementing mode (mode bit 0), beat k of a line uses line start + 8·k.
- R4: In constant mode (mode bit 1), every beat of a line uses that line's start address.
- R5: Line n of a side starts at the request's start address + n × that side's signed stride (two's complement, sign-extended, modulo the address width). This holds in both modes.
- R6: The 64-bit word written for a beat equals the word read for that beat. Reads and writes never overlap: a beat's write follows its read response.
- R7: `rd_prio` and `wr_prio` carry the priority field of the request that issues the access.
- R8: A line length of zero, or one whose low 3 bits are not all zero, produces a completion with `done_err`=1 and no memory access. This takes precedence over R11.
- R9: A read or write response with its error bit set ends the request. No further beat of that request is issued, and it completes with `done_err`=1 and its own tag.
- R10: Completions come in acceptance order as one-cycle `done_valid` pulses carrying the request tag. `done_err` is 0 for a request that moved all its beats.
- R11: A valid line length with a line count of zero completes with `done_err`=0 and no memory access.
- R12: While `rd_valid` or `wr_valid` waits for its ready, it stays asserted, and its address (and write data) stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request table has room |
| req_src | input | AW | Source start address |
| req_dst | input | AW | Destination start address |
| req_acnt | input | CW | Bytes per line |
| req_bcnt | input | CW | Number of lines |
| req_sidx | input | IW | Signed source line stride |
| req_didx | input | IW | Signed destination line stride |
| req_sconst | input | 1 | Source constant-address mode |
| req_dconst | input | 1 | Destination constant-address mode |
| req_prio | input | PW | Priority level for the request's accesses |
| req_tag | input | TW | Tag returned on completion |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read beat address |
| rd_prio | output | PW | Read priority |
| rd_rsp_valid | input | 1 | Read response |
| rd_rsp_data | input | DW | Read data |
| rd_rsp_err | input | 1 | Read error response |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | AW | Write beat address |
| wr_data | output | DW | Write data |
| wr_prio | output | PW | Write priority |
| wr_rsp_valid | input | 1 | Write response |
| wr_rsp_err | input | 1 | Write error response |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TW | Tag of the completed request |
| done_err | output | 1 | Completed request failed |

## Verification
The bench builds the engine with a 16-bit address, 8-bit counts and strides, a 2-bit priority and a 3-bit tag, with the table depth kept at 4. The narrow tag makes tag reuse occur within the run, and a depth of 4 lets the memory model hold the read port long enough to fill the table. The small count width keeps a full sweep affordable: line lengths 8 to 24 bytes, 1 to 3 lines, all four mode pairs and two stride sets, including negative strides. Expected addresses and data come from arithmetic on the request fields.

// File: rtl/blk2d_pkg.sv
package blk2d_pkg;

    // Sequencer states of the copy engine
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_RD_ADDR,
        S_RD_WAIT,
        S_WR_ADDR,
        S_WR_WAIT,
        S_RETIRE
    } eng_state_e;

endpackage

// File: rtl/blk2d_req_fifo.sv
// In-order table of accepted requests; the head is the running request.
module blk2d_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);

    logic [W-1:0]    slots [DEPTH];
    logic [PTRW-1:0] wp_q, rp_q;
    logic [CNTW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (push) slots[wp_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q   <= '0;
            rp_q   <= '0;
            used_q <= '0;
        end else begin
            if (push) wp_q <= (wp_q == LAST) ? '0 : wp_q + PTRW'(1);
            if (pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + PTRW'(1);
            unique case ({push, pop})
                2'b10:   used_q <= used_q + CNTW'(1);
                2'b01:   used_q <= used_q - CNTW'(1);
                default: used_q <= used_q;
            endcase
        end
    end

    assign head  = slots[rp_q];
    assign empty = (used_q == '0);
    assign full  = (used_q == CNTW'(DEPTH));

endmodule

// File: rtl/blk2d_side_addr.sv
// Address walker for one side: line base plus per-beat offset.
module blk2d_side_addr #(
    parameter int AW   = 32,
    parameter int IW   = 16,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          adv,
    input  logic          new_line,
    input  logic          hold_addr,
    input  logic [IW-1:0] line_idx,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] line_q, addr_q, idx_ext, next_line;

    assign idx_ext   = {{(AW-IW){line_idx[IW-1]}}, line_idx};
    assign next_line = line_q + idx_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            line_q <= base;
            addr_q <= base;
        end else if (adv) begin
            if (new_line) begin
                line_q <= next_line;
                addr_q <= next_line;
            end else if (!hold_addr) begin
                addr_q <= addr_q + AW'(STEP);
            end
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/blk2d_engine.sv
// Beat sequencer: one read, then one write, per beat.
module blk2d_engine
    import blk2d_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int IW = 16,
    parameter int PW = 3,
    parameter int TW = 4,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          job_valid,
    input  logic [AW-1:0] job_src,
    input  logic [AW-1:0] job_dst,
    input  logic [CW-1:0] job_acnt,
    input  logic [CW-1:0] job_bcnt,
    input  logic [IW-1:0] job_sidx,
    input  logic [IW-1:0] job_didx,
    input  logic          job_sconst,
    input  logic          job_dconst,
    input  logic [PW-1:0] job_prio,
    input  logic [TW-1:0] job_tag,
    output logic          job_pop,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_prio,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    input  logic          rd_rsp_err,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [PW-1:0] wr_prio,
    input  logic          wr_rsp_valid,
    input  logic          wr_rsp_err,
    output logic          done_valid,
    output logic [TW-1:0] done_tag,
    output logic          done_err
);
    localparam int BEAT_BYTES = DW / 8;
    localparam int BSH        = $clog2(BEAT_BYTES);

    eng_state_e    state_q, state_d;
    logic [CW-1:0] beats_q, lines_q, beats_per_line;
    logic [DW-1:0] data_q;
    logic          err_q;
    logic          bad_len, rd_ok, rd_bad, wr_ok, wr_bad;
    logic          last_in_line, last_beat, load_sides;
    logic [AW-1:0] src_addr, dst_addr;

    assign beats_per_line = job_acnt >> BSH;
    assign bad_len        = (job_acnt == '0) || (job_acnt[BSH-1:0] != '0);
    assign rd_ok  = (state_q == S_RD_WAIT) && rd_rsp_valid && !rd_rsp_err;
    assign rd_bad = (state_q == S_RD_WAIT) && rd_rsp_valid &&  rd_rsp_err;
    assign wr_ok  = (state_q == S_WR_WAIT) && wr_rsp_valid && !wr_rsp_err;
    assign wr_bad = (state_q == S_WR_WAIT) && wr_rsp_valid &&  wr_rsp_err;
    assign last_in_line = (beats_q == CW'(1));
    assign last_beat    = last_in_line && (lines_q == CW'(1));
    assign load_sides   = (state_q == S_LOAD);

    blk2d_side_addr #(.AW(AW), .IW(IW), .STEP(BEAT_BYTES)) u_src (
        .clk(clk), .rst_n(rst_n), .load(load_sides), .base(job_src),
        .adv(wr_ok), .new_line(last_in_line), .hold_addr(job_sconst),
        .line_idx(job_sidx), .addr(src_addr)
    );

    blk2d_side_addr #(.AW(AW), .IW(IW), .STEP(BEAT_BYTES)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(load_sides), .base(job_dst),
        .adv(wr_ok), .new_line(last_in_line), .hold_addr(job_dconst),
        .line_idx(job_didx), .addr(dst_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (job_valid) state_d = S_LOAD;
            S_LOAD:    state_d = (bad_len || job_bcnt == '0) ? S_RETIRE : S_RD_ADDR;
            S_RD_ADDR: if (rd_ready) state_d = S_RD_WAIT;
            S_RD_WAIT: if (rd_ok) state_d = S_WR_ADDR;
                       else if (rd_bad) state_d = S_RETIRE;
            S_WR_ADDR: if (wr_ready) state_d = S_WR_WAIT;
            S_WR_WAIT: if (wr_bad || (wr_ok && last_beat)) state_d = S_RETIRE;
                       else if (wr_ok) state_d = S_RD_ADDR;
            S_RETIRE:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_valid   = (state_q == S_RD_ADDR);
        wr_valid   = (state_q == S_WR_ADDR);
        done_valid = (state_q == S_RETIRE);
        job_pop    = (state_q == S_RETIRE);
        rd_addr    = src_addr;
        wr_addr    = dst_addr;
        wr_data    = data_q;
        rd_prio    = job_prio;
        wr_prio    = job_prio;
        done_tag   = job_tag;
        done_err   = err_q;
    end

    // Beat and line counters, data holding register, error status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beats_q <= '0;
            lines_q <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            if (state_q == S_LOAD) begin
                beats_q <= beats_per_line;
                lines_q <= job_bcnt;
                err_q   <= bad_len;
            end
            if (rd_ok) data_q <= rd_rsp_data;
            if (rd_bad || wr_bad) err_q <= 1'b1;
            if (wr_ok) begin
                if (last_in_line) begin
                    beats_q <= beats_per_line;
                    lines_q <= lines_q - CW'(1);
                end else begin
                    beats_q <= beats_q - CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/blk2d_mover.sv
// Top: request table in front of the beat sequencer.
module blk2d_mover #(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int IW    = 16,
    parameter int PW    = 3,
    parameter int TW    = 4,
    parameter int DW    = 64,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_src,
    input  logic [AW-1:0] req_dst,
    input  logic [CW-1:0] req_acnt,
    input  logic [CW-1:0] req_bcnt,
    input  logic [IW-1:0] req_sidx,
    input  logic [IW-1:0] req_didx,
    input  logic          req_sconst,
    input  logic          req_dconst,
    input  logic [PW-1:0] req_prio,
    input  logic [TW-1:0] req_tag,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] rd_addr,
    output logic [PW-1:0] rd_prio,
    input  logic          rd_rsp_valid,
    input  logic [DW-1:0] rd_rsp_data,
    input  logic          rd_rsp_err,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [PW-1:0] wr_prio,
    input  logic          wr_rsp_valid,
    input  logic          wr_rsp_err,
    output logic          done_valid,
    output logic [TW-1:0] done_tag,
    output logic          done_err
);
    localparam int REQW = 2*AW + 2*CW + 2*IW + 2 + PW + TW;

    logic [REQW-1:0] head;
    logic            empty, full, pop;
    logic [AW-1:0]   h_src, h_dst;
    logic [CW-1:0]   h_acnt, h_bcnt;
    logic [IW-1:0]   h_sidx, h_didx;
    logic            h_sconst, h_dconst;
    logic [PW-1:0]   h_prio;
    logic [TW-1:0]   h_tag;

    assign req_ready = !full;

    blk2d_req_fifo #(.W(REQW), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n),
        .push(req_valid && !full),
        .push_data({req_tag, req_prio, req_dconst, req_sconst, req_didx,
                    req_sidx, req_bcnt, req_acnt, req_dst, req_src}),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    assign {h_tag, h_prio, h_dconst, h_sconst, h_didx,
            h_sidx, h_bcnt, h_acnt, h_dst, h_src} = head;

    blk2d_engine #(.AW(AW), .CW(CW), .IW(IW), .PW(PW), .TW(TW), .DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n), .job_valid(!empty),
        .job_src(h_src), .job_dst(h_dst), .job_acnt(h_acnt), .job_bcnt(h_bcnt),
        .job_sidx(h_sidx), .job_didx(h_didx),
        .job_sconst(h_sconst), .job_dconst(h_dconst),
        .job_prio(h_prio), .job_tag(h_tag), .job_pop(pop),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_prio(rd_prio),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_prio(wr_prio), .wr_rsp_valid(wr_rsp_valid), .wr_rsp_err(wr_rsp_err),
        .done_valid(done_valid), .done_tag(done_tag), .done_err(done_err)
    );

endmodule

// File: rtl/blk2d_mover_chk.sv
// Port-level properties of the copy engine, bound to the top.
module blk2d_mover_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          done_valid
);
    localparam int LW = $clog2(DEPTH + 2) + 1;

    logic [LW-1:0] live_q;
    logic          acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else begin
            unique case ({acc, done_valid})
                2'b10:   live_q <= live_q + LW'(1);
                2'b01:   live_q <= live_q - LW'(1);
                default: live_q <= live_q;
            endcase
        end
    end

    assert_inflight_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q <= LW'(DEPTH));

    assert_full_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == LW'(DEPTH)) |-> !req_ready);

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_valid));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_done_has_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (live_q != '0));

endmodule

bind blk2d_mover blk2d_mover_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_valid(done_valid)
);

// File: tb/sim_blk2d_mover.sv
`timescale 1ns/1ps
module sim_blk2d_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_src = '0, req_dst = '0;
    logic [7:0]  req_acnt = '0, req_bcnt = '0, req_sidx = '0, req_didx = '0;
    logic        req_sconst = 1'b0, req_dconst = 1'b0;
    logic [1:0]  req_prio = '0;
    logic [2:0]  req_tag = '0;
    logic        rd_valid, rd_ready = 1'b0;
    logic [15:0] rd_addr;
    logic [1:0]  rd_prio;
    logic        rd_rsp_valid = 1'b0, rd_rsp_err = 1'b0;
    logic [63:0] rd_rsp_data = '0;
    logic        wr_valid, wr_ready = 1'b0;
    logic [15:0] wr_addr;
    logic [63:0] wr_data;
    logic [1:0]  wr_prio;
    logic        wr_rsp_valid = 1'b0, wr_rsp_err = 1'b0;
    logic        done_valid, done_err;
    logic [2:0]  done_tag;

    always #4 clk = ~clk;

    blk2d_mover #(.AW(16), .CW(8), .IW(8), .PW(2), .TW(3), .DW(64), .DEPTH(4)) u0 (.*);

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [15:0] q_rd_addr[$]; logic [1:0] q_rd_prio[$]; logic [2:0] q_rd_tag[$];
    logic [15:0] q_wr_addr[$]; logic [63:0] q_wr_data[$];
    logic [1:0]  q_wr_prio[$]; logic [2:0] q_wr_tag[$];
    logic [2:0]  q_dn_tag[$];  logic q_dn_err[$];

    bit hold_mem = 0;
    int inj_rd = -1, inj_wr = -1, rd_count = 0, wr_count = 0;
    logic [2:0] next_tag = '0;

    function automatic logic [63:0] pat(input logic [15:0] a);
        return {a, ~a, a ^ 16'h5a5a, a + 16'h0101};
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Drop the remaining beats of the running request and mark it failed (R9)
    task automatic flush_req(input logic [2:0] t);
        while (q_rd_tag.size() > 0 && q_rd_tag[0] == t) begin
            void'(q_rd_addr.pop_front()); void'(q_rd_prio.pop_front()); void'(q_rd_tag.pop_front());
        end
        while (q_wr_tag.size() > 0 && q_wr_tag[0] == t) begin
            void'(q_wr_addr.pop_front()); void'(q_wr_data.pop_front());
            void'(q_wr_prio.pop_front()); void'(q_wr_tag.pop_front());
        end
        if (q_dn_tag.size() > 0) q_dn_err[0] = 1'b1;
    endtask

    // Memory model and port monitor, active between clock edges
    initial begin
        bit rd_pend = 0, wr_pend = 0;
        logic [15:0] rd_pa = '0;
        logic [2:0] rd_pt = '0, wr_pt = '0;
        int rd_pi = 0, wr_pi = 0, cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_rsp_valid = rd_pend; rd_rsp_err = 1'b0;
            if (rd_pend) begin
                rd_rsp_data = pat(rd_pa);
                if (rd_pi == inj_rd) begin rd_rsp_err = 1'b1; flush_req(rd_pt); end
            end
            rd_pend = 0;
            wr_rsp_valid = wr_pend; wr_rsp_err = 1'b0;
            if (wr_pend && wr_pi == inj_wr) begin wr_rsp_err = 1'b1; flush_req(wr_pt); end
            wr_pend = 0;
            rd_ready = !hold_mem && (cyc % 3 != 0);
            wr_ready = !hold_mem && (cyc % 4 != 1);
            if (rd_valid && rd_ready) begin
                if (q_rd_tag.size() == 0) chk(0, "R8/R11 unexpected read", 64'(rd_addr), 0);
                else begin
                    chk(rd_addr == q_rd_addr[0], "R3/R4/R5 read address", 64'(rd_addr), 64'(q_rd_addr[0]));
                    chk(rd_prio == q_rd_prio[0], "R7 read priority", 64'(rd_prio), 64'(q_rd_prio[0]));
                    rd_pt = q_rd_tag[0];
                    void'(q_rd_addr.pop_front()); void'(q_rd_prio.pop_front()); void'(q_rd_tag.pop_front());
                end
                rd_pend = 1; rd_pa = rd_addr; rd_pi = rd_count; rd_count++;
            end
            if (wr_valid && wr_ready) begin
                if (q_wr_tag.size() == 0) chk(0, "R9 unexpected write", 64'(wr_addr), 0);
                else begin
                    chk(wr_addr == q_wr_addr[0], "R3/R4/R5 write address", 64'(wr_addr), 64'(q_wr_addr[0]));
                    chk(wr_data == q_wr_data[0], "R6 write data", wr_data, q_wr_data[0]);
                    chk(wr_prio == q_wr_prio[0], "R7 write priority", 64'(wr_prio), 64'(q_wr_prio[0]));
                    wr_pt = q_wr_tag[0];
                    void'(q_wr_addr.pop_front()); void'(q_wr_data.pop_front());
                    void'(q_wr_prio.pop_front()); void'(q_wr_tag.pop_front());
                end
                wr_pend = 1; wr_pi = wr_count; wr_count++;
            end
            if (done_valid) begin
                if (q_dn_tag.size() == 0) chk(0, "R10 unexpected completion", 64'(done_tag), 0);
                else begin
                    chk(done_tag == q_dn_tag[0], "R10 completion tag order", 64'(done_tag), 64'(q_dn_tag[0]));
                    chk(done_err == q_dn_err[0], "R8/R9/R10/R11 completion status", 64'(done_err), 64'(q_dn_err[0]));
                    void'(q_dn_tag.pop_front()); void'(q_dn_err.pop_front());
                end
            end
        end
    end

    // Queue the expected beats, then offer the request (called at a negedge)
    task automatic send(input logic [15:0] src, input logic [15:0] dst,
                        input logic [7:0] acnt, input logic [7:0] bcnt,
                        input logic [7:0] sidx, input logic [7:0] didx,
                        input logic sc, input logic dc, input logic [1:0] prio);
        logic [2:0] t = next_tag;
        bit bad = (acnt == 0) || (acnt[2:0] != 3'd0);
        next_tag = next_tag + 3'd1;
        if (!bad) begin
            for (int l = 0; l < int'(bcnt); l++) begin
                logic [15:0] sl = src + 16'(l) * {{8{sidx[7]}}, sidx};
                logic [15:0] dl = dst + 16'(l) * {{8{didx[7]}}, didx};
                for (int k = 0; k < int'(acnt) / 8; k++) begin
                    logic [15:0] sa = sc ? sl : sl + 16'(8 * k);
                    logic [15:0] da = dc ? dl : dl + 16'(8 * k);
                    q_rd_addr.push_back(sa); q_rd_prio.push_back(prio); q_rd_tag.push_back(t);
                    q_wr_addr.push_back(da); q_wr_data.push_back(pat(sa));
                    q_wr_prio.push_back(prio); q_wr_tag.push_back(t);
                end
            end
        end
        q_dn_tag.push_back(t); q_dn_err.push_back(bad);
        req_src = src; req_dst = dst; req_acnt = acnt; req_bcnt = bcnt;
        req_sidx = sidx; req_didx = didx; req_sconst = sc; req_dconst = dc;
        req_prio = prio; req_tag = t; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_dn_tag.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(q_rd_tag.size() == 0 && q_wr_tag.size() == 0, "R9/R10 beats left over",
            64'(q_rd_tag.size() + q_wr_tag.size()), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 1);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", 64'(rd_valid), 0);
        chk(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 0);
        chk(done_valid == 1'b0, "R1 done_valid after reset", 64'(done_valid), 0);

        // Sweep: lengths, line counts, mode pairs and strides (R3 R4 R5 R6 R7 R10)
        for (int a = 1; a <= 3; a++)
            for (int b = 1; b <= 3; b++)
                for (int m = 0; m < 4; m++)
                    for (int s = 0; s < 2; s++)
                        send(16'h1000 + 16'(a * 16'h100), 16'h8000 + 16'(m * 16'h200),
                             8'(8 * a), 8'(b),
                             s ? 8'hF8 : 8'd32, s ? 8'd0 : 8'hE8,
                             m[0], m[1], 2'(a + m));
        drain();

        // R8 bad lengths, R11 zero lines
        send(16'h2000, 16'h3000, 8'd0,  8'd2, 8'd8, 8'd8, 0, 0, 2'd1);
        send(16'h2000, 16'h3000, 8'd4,  8'd2, 8'd8, 8'd8, 0, 0, 2'd2);
        send(16'h2000, 16'h3000, 8'd12, 8'd1, 8'd8, 8'd8, 1, 0, 2'd3);
        send(16'h2000, 16'h3000, 8'd20, 8'd0, 8'd8, 8'd8, 0, 1, 2'd0);
        send(16'h2000, 16'h3000, 8'd16, 8'd0, 8'd8, 8'd8, 0, 0, 2'd1);
        drain();

        // R9 read error on the third beat, then write error on the second beat
        inj_rd = rd_count + 2;
        send(16'h4000, 16'h5000, 8'd16, 8'd3, 8'd64, 8'd64, 0, 0, 2'd2);
        drain();
        inj_wr = wr_count + 1;
        send(16'h4400, 16'h5400, 8'd24, 8'd2, 8'd32, 8'hE0, 0, 1, 2'd3);
        drain();
        send(16'h4800, 16'h5800, 8'd16, 8'd2, 8'd16, 8'd16, 0, 0, 2'd1);
        drain();

        // R2 table full while the read port is held; R12 read request held stable
        hold_mem = 1;
        for (int i = 0; i < 4; i++)
            send(16'h6000 + 16'(i * 64), 16'h7000, 8'd8, 8'd1, 8'd0, 8'd0, 0, 0, 2'(i));
        for (int i = 0; i < 6; i++) begin
            chk(req_ready == 1'b0, "R2 req_ready with four outstanding", 64'(req_ready), 0);
            chk(rd_valid == 1'b1 && rd_addr == 16'h6000, "R12 held read request",
                64'({rd_valid, rd_addr}), 64'({1'b1, 16'h6000}));
            @(negedge clk);
        end
        hold_mem = 0;
        drain();
        chk(req_ready == 1'b1, "R2 req_ready after drain", 64'(req_ready), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule